// File: doc/BRIEF.md
# Indexed Effective Address Generator with Boundary Check

This block turns an instruction's storage address field into an effective address. It can add an increment taken from a general register that serves as an index. The caller presents the address field, the 4-bit number of the index register, the 32-bit contents already read from that register, and a code for the operand length, then pulses `start`. One clock later the block presents the 24-bit effective address with a one-cycle valid strobe.

At the same edge the block reports whether that address sits on an integral boundary for the operand length. An operand that does not sit on such a boundary raises the specification-exception flag. The address is still driven in that case, but the consumer must not use it for a storage access.

Register number 0 means that no index is applied. The block never writes back to the register or the instruction. It only reads its inputs, and any carry beyond the address width is dropped.

Top module: `idx_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `ea`, `ea_valid` and `spec_exc` are all 0 until the first `start`.
- R2: `ea_valid` is 1 in exactly the cycle that follows a cycle with `start` = 1, and 0 in every other cycle.
- R3: When `idx_num` is nonzero, `ea` equals `addr_field` plus the low 24 bits of `idx_value`, sampled in the `start` cycle.
- R4: When `idx_num` is 0, `ea` equals `addr_field` and `idx_value` has no effect on any output.
- R5: The addition is modulo 2^24, and a carry out of bit 23 (LSB = bit 0) is discarded without any other effect.
- R6: Size code 0 (byte) never raises `spec_exc`.
- R7: Size code 1 (halfword) raises `spec_exc` exactly when `ea[0]` is 1.
- R8: Size code 2 (word) raises `spec_exc` exactly when `ea[1:0]` is nonzero.
- R9: Size code 3 (doubleword) raises `spec_exc` exactly when `ea[2:0]` is nonzero.
- R10: `spec_exc` is asserted only in a cycle in which `ea_valid` is also asserted.
- R11: `ea` holds its last value in every cycle that does not follow a `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Requests one address calculation this cycle |
| addr_field | input | 24 | Address field taken from the instruction |
| idx_num | input | 4 | Number of the index register, 0 = no index |
| idx_value | input | 32 | Contents of the named index register |
| op_size | input | 2 | Operand length: 0 byte, 1 halfword, 2 word, 3 doubleword |
| ea | output | 24 | Effective address, registered |
| ea_valid | output | 1 | One-cycle strobe marking a new result |
| spec_exc | output | 1 | Operand is not on its boundary, so `ea` must not be used |

## Verification
The assertions assume that all inputs are sampled only in cycles where `start` is 1, and that `start` may be held high on consecutive cycles, each cycle counting as a new request. They also assume reset is applied once at the beginning. The bench changes its inputs only on falling edges, so every value is settled before the sampling edge. It drives `idx_value` with large or arbitrary values while `idx_num` is 0, so that the suppression is tested against values that would otherwise change the sum. Address fields close to the top of the range force the wrap.

// File: rtl/idx_addr_gen_pkg.sv
package idx_addr_gen_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } opnd_size_e;

  // Low-order address bits that must be zero for an operand length
  function automatic logic [2:0] align_mask(input opnd_size_e sz);
    case (sz)
      SZ_HALF: align_mask = 3'b001;
      SZ_WORD: align_mask = 3'b011;
      SZ_DBL:  align_mask = 3'b111;
      default: align_mask = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/idx_select.sv
module idx_select #(
  parameter int IDX_W = 4,
  parameter int REG_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic [IDX_W-1:0]  idx_num,
  input  logic [REG_W-1:0]  idx_value,
  output logic [ADDR_W-1:0] incr
);
  // Register 0 names no index, so the increment is forced to zero
  logic use_index;
  assign use_index = (idx_num != '0);
  assign incr = use_index ? idx_value[ADDR_W-1:0] : '0;
endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] incr,
  output logic [ADDR_W-1:0] sum,
  output logic              carry_out
);
  logic [ADDR_W:0] wide;
  assign wide      = {1'b0, base_addr} + {1'b0, incr};
  assign sum       = wide[ADDR_W-1:0];
  assign carry_out = wide[ADDR_W];   // brought out but deliberately unused
endmodule

// File: rtl/align_check.sv
module align_check
  import idx_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  opnd_size_e        size,
  output logic              misaligned
);
  logic [2:0] mask;
  assign mask       = align_mask(size);
  assign misaligned = |(addr[2:0] & mask);
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import idx_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int REG_W  = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_field,
  input  logic [IDX_W-1:0]  idx_num,
  input  logic [REG_W-1:0]  idx_value,
  input  logic [1:0]        op_size,
  output logic [ADDR_W-1:0] ea,
  output logic              ea_valid,
  output logic              spec_exc
);

  // Named internal events
  logic [ADDR_W-1:0] incr_w;
  logic [ADDR_W-1:0] sum_w;
  logic              carry_w;
  logic              misalign_w;
  opnd_size_e        size_w;

  assign size_w = opnd_size_e'(op_size);

  idx_select #(.IDX_W(IDX_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_sel (
    .idx_num   (idx_num),
    .idx_value (idx_value),
    .incr      (incr_w)
  );

  ea_adder #(.ADDR_W(ADDR_W)) u_add (
    .base_addr (addr_field),
    .incr      (incr_w),
    .sum       (sum_w),
    .carry_out (carry_w)
  );

  align_check #(.ADDR_W(ADDR_W)) u_chk (
    .addr       (sum_w),
    .size       (size_w),
    .misaligned (misalign_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea       <= '0;
      ea_valid <= 1'b0;
      spec_exc <= 1'b0;
    end else begin
      ea_valid <= start;
      spec_exc <= start & misalign_w;
      if (start) ea <= sum_w;
    end
  end

  // R2: a request produces a strobe on the next cycle
  p_valid_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ea_valid);

  // R2: no strobe without a request the cycle before
  p_valid_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !ea_valid);

  // R4: no index register means the address field passes through unchanged
  p_no_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idx_num == '0) |=> ea == $past(addr_field));

  // R10: exception only comes with a strobe
  p_exc_with_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spec_exc |-> ea_valid);

  // R9: an exception implies some low-order address bit is set
  p_exc_low_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spec_exc |-> (ea[2:0] != 3'b000));

  // R6: a byte request never flags an exception
  p_byte_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_size == 2'd0) |=> !spec_exc);

  // R11: address holds between requests
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(ea));

endmodule

// File: tb/tb_idx_addr_gen.sv
`timescale 1ns/1ps
module tb_idx_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] addr_field = '0;
  logic [3:0]  idx_num = '0;
  logic [31:0] idx_value = '0;
  logic [1:0]  op_size = '0;
  logic [23:0] ea;
  logic        ea_valid;
  logic        spec_exc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state, updated behaviourally once per clock
  longint exp_ea = 0;
  bit     exp_valid = 0;
  bit     exp_exc = 0;
  string  ea_tag = "R1";
  string  exc_tag = "R1";

  always #10 clk = ~clk;   // 50 MHz

  idx_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_field(addr_field),
    .idx_num(idx_num), .idx_value(idx_value), .op_size(op_size),
    .ea(ea), .ea_valid(ea_valid), .spec_exc(spec_exc)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compute next expected outputs from the currently driven inputs
  task automatic model_step();
    longint inc;
    longint sum;
    int modv;
    if (start) begin
      inc = (idx_num == 0) ? 0 : (idx_value % (1 << 24));
      sum = (addr_field + inc) % (1 << 24);
      case (op_size)
        2'd1: modv = 2;
        2'd2: modv = 4;
        2'd3: modv = 8;
        default: modv = 1;
      endcase
      exp_ea    = sum;
      exp_valid = 1;
      exp_exc   = (sum % modv) != 0;
      if (idx_num == 0) ea_tag = "R4";
      else if (addr_field + inc >= (1 << 24)) ea_tag = "R5";
      else ea_tag = "R3";
      case (op_size)
        2'd0: exc_tag = "R6";
        2'd1: exc_tag = "R7";
        2'd2: exc_tag = "R8";
        default: exc_tag = "R9";
      endcase
    end else begin
      exp_valid = 0;
      exp_exc   = 0;
      ea_tag    = "R11";
      exc_tag   = "R10";
    end
  endtask

  // One cycle: drive at falling edge, clock, compare at next falling edge
  task automatic cyc(bit s, logic [23:0] a, logic [3:0] n, logic [31:0] v, logic [1:0] sz);
    start = s; addr_field = a; idx_num = n; idx_value = v; op_size = sz;
    model_step();
    @(negedge clk);
    check("R2", "ea_valid", ea_valid, exp_valid);
    check(exc_tag, "spec_exc", spec_exc, exp_exc);
    check(ea_tag, "ea", ea, exp_ea);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset ea", ea, 0);
    check("R1", "reset ea_valid", ea_valid, 0);
    check("R1", "reset spec_exc", spec_exc, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "post-reset ea_valid", ea_valid, 0);
    check("R1", "post-reset ea", ea, 0);

    // R3 plain index add, aligned word
    cyc(1, 24'h001000, 4'd5, 32'h0000_0204, 2'd2);
    // R11 idle hold
    cyc(0, 24'hFFFFFF, 4'd1, 32'hFFFF_FFFF, 2'd3);
    // R4 register 0 with junk value
    cyc(1, 24'h000123, 4'd0, 32'hDEAD_BEEF, 2'd0);
    // R5 wrap past top, high register bits ignored
    cyc(1, 24'hFFFFF8, 4'd15, 32'hAB00_0010, 2'd3);
    // R7 halfword odd / even
    cyc(1, 24'h000100, 4'd2, 32'h0000_0001, 2'd1);
    cyc(1, 24'h000100, 4'd2, 32'h0000_0002, 2'd1);
    // R8 word misaligned by 2
    cyc(1, 24'h000200, 4'd3, 32'h0000_0002, 2'd2);
    // R9 doubleword misaligned by 4, then aligned
    cyc(1, 24'h000204, 4'd0, 32'h0000_0004, 2'd3);
    cyc(1, 24'h000208, 4'd0, 32'h0000_0003, 2'd3);
    // R6 byte at odd address
    cyc(1, 24'h000007, 4'd9, 32'h0000_0000, 2'd0);
    cyc(0, 24'h0, 4'd0, 32'h0, 2'd0);
    cyc(0, 24'h0, 4'd0, 32'h0, 2'd0);

    for (int i = 0; i < 400; i++) begin
      cyc(($urandom % 3) != 0, 24'($urandom), 4'($urandom % 4 == 0 ? 0 : $urandom),
          $urandom, 2'($urandom));
    end
    cyc(0, 24'h0, 4'd0, 32'h0, 2'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule